// File: doc/BRIEF.md
# Adaptive-Step One-Bit Boundary Quantizer

This block reduces a stream of 8-bit pixels to one bit per pixel. Each pixel arrives Gray-coded and is converted to plain binary. It is then compared with a single boundary point, and the result of that comparison is the output bit. After every pixel the boundary point moves towards the pixel by a step. In adaptive mode the step also changes. It grows by one eighth when the same output bit appears twice in a row, and it drops back to its programmed start value as soon as the bit flips. In fixed mode the step never changes.

A scan controller sits beside the block. It starts each frame with a start strobe, which puts the boundary point back at mid-range and reloads the step. It can also overwrite the boundary point at any time through a load port. It reads the live boundary point back on an output so it can save the value and restore it later. The quantized bit appears one cycle after its pixel. The boundary-point and step updates land on that same clock edge.

Top module: `adq_quantizer`

## Requirements
- R1: The pixel input is Gray-coded. The value compared is its binary equivalent, where bit i of the binary value is the XOR of Gray bits i through 7.
- R2: Reset and the frame-start strobe each set the boundary point to 128 and clear the bit history. Reset sets the step to 16. Frame start sets the step to the programmed start value. A pixel that arrives with the frame-start strobe is quantized against these restored values.
- R3: The output bit is 1 when the binary pixel is strictly greater than the boundary point, and 0 otherwise. The output-valid strobe is the pixel-valid strobe delayed by exactly one cycle. The output bit holds its value when no pixel arrives.
- R4: After a pixel that produced a 1, the boundary point rises by the step and saturates at 255.
- R5: After a pixel that produced a 0, the boundary point falls by the step and saturates at 0.
- R6: In adaptive mode (mode input 1), when the new bit equals the previous bit of the same frame, the step becomes step + floor(step/8), saturating at 255.
- R7: In adaptive mode, when the new bit differs from the previous bit, the step returns to the programmed start value. The first pixel of a frame, which has no previous bit, leaves the step unchanged.
- R8: In fixed mode (mode input 0), pixels never change the step.
- R9: A load strobe writes the supplied value into the boundary point on the next edge. The load overrides both the pixel update and the frame-start value. A pixel in the same cycle is still compared against the old boundary point, and it still updates the step and the bit history.
- R10: In a cycle with no pixel, no load and no frame start, the boundary point, the step and the output bit keep their values, and the output-valid strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| px_valid_i | input | 1 | A pixel is present this cycle |
| px_gray_i | input | 8 | Gray-coded pixel value |
| frame_start_i | input | 1 | Restores the frame-start state; may come with the first pixel |
| adapt_mode_i | input | 1 | 1 = adaptive step, 0 = fixed step |
| step_init_i | input | 8 | Programmed start value of the step |
| bp_load_i | input | 1 | Overwrites the boundary point |
| bp_load_val_i | input | 8 | Value written by the load strobe |
| q_valid_o | output | 1 | Output bit valid, one cycle after the pixel |
| q_bit_o | output | 1 | Quantized bit |
| bp_o | output | 8 | Current boundary point, for read-back and restore |
| step_o | output | 8 | Current step |

## Verification
The assertions check several things on every cycle. The output-valid strobe is the delayed pixel strobe. The boundary point moves in the direction given by the output bit. A load lands exactly on the next edge. Idle cycles and fixed mode leave the step alone. A standalone frame start returns the boundary point to mid-range. Other properties depend on exact arithmetic, and only the bench scenarios show them. These are the exact comparison threshold across every Gray code, the saturation at both ends of the boundary point and at the top of the step, the one-eighth step growth and its reset on a bit flip, and the priority of a load over a frame start in the same cycle. The bench checks these against a model of the arithmetic that it computes for itself.

// File: rtl/adq_pkg.sv
package adq_pkg;
  typedef enum logic {
    STEP_FIXED = 1'b0,
    STEP_ADAPT = 1'b1
  } step_mode_e;

  localparam int unsigned ADQ_PIX_W      = 8;
  localparam int unsigned ADQ_GROW_SHIFT = 3;
endpackage

// File: rtl/adq_rst_sync.sv
module adq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/adq_gray2bin.sv
module adq_gray2bin #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  assign bin_o[W-1] = gray_i[W-1];

  for (genvar i = W - 2; i >= 0; i--) begin : g_bit
    assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
  end
endmodule

// File: rtl/adq_bp_update.sv
module adq_bp_update #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] bp_i,
  input  logic [W-1:0] step_i,
  input  logic         up_i,
  output logic [W-1:0] bp_next_o
);
  logic [W-1:0] opnd;
  logic [W:0]   sum;

  // subtraction reuses the adder: inverted operand plus carry-in
  always_comb begin
    opnd = up_i ? step_i : ~step_i;
    sum  = {1'b0, bp_i} + {1'b0, opnd} + {{W{1'b0}}, ~up_i};
    if (up_i) bp_next_o = sum[W] ? {W{1'b1}} : sum[W-1:0];
    else      bp_next_o = sum[W] ? sum[W-1:0] : {W{1'b0}};
  end
endmodule

// File: rtl/adq_step_ctrl.sv
module adq_step_ctrl
  import adq_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned SHIFT = 3
) (
  input  logic [W-1:0] step_i,
  input  logic [W-1:0] step_init_i,
  input  step_mode_e   mode_i,
  input  logic         have_prev_i,
  input  logic         prev_bit_i,
  input  logic         cur_bit_i,
  output logic [W-1:0] step_next_o
);
  logic [W:0] grown;

  always_comb begin
    grown = {1'b0, step_i} + {1'b0, (step_i >> SHIFT)};
    step_next_o = step_i;
    if (mode_i == STEP_ADAPT && have_prev_i) begin
      if (prev_bit_i == cur_bit_i) step_next_o = grown[W] ? {W{1'b1}} : grown[W-1:0];
      else                         step_next_o = step_init_i;
    end
  end
endmodule

// File: rtl/adq_quantizer.sv
module adq_quantizer
  import adq_pkg::*;
#(
  parameter int unsigned PIX_W    = ADQ_PIX_W,
  parameter int unsigned SHIFT    = ADQ_GROW_SHIFT,
  parameter int unsigned STEP_RST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             px_valid_i,
  input  logic [PIX_W-1:0] px_gray_i,
  input  logic             frame_start_i,
  input  logic             adapt_mode_i,
  input  logic [PIX_W-1:0] step_init_i,
  input  logic             bp_load_i,
  input  logic [PIX_W-1:0] bp_load_val_i,
  output logic             q_valid_o,
  output logic             q_bit_o,
  output logic [PIX_W-1:0] bp_o,
  output logic [PIX_W-1:0] step_o
);
  localparam logic [PIX_W-1:0] BP_MID   = PIX_W'(1) << (PIX_W - 1);
  localparam logic [PIX_W-1:0] STEP_R0  = PIX_W'(STEP_RST);

  logic             rst_ns;
  logic [PIX_W-1:0] pix_bin;
  logic [PIX_W-1:0] bp_q, bp_d, eff_bp, bp_upd;
  logic [PIX_W-1:0] step_q, step_d, eff_step, step_upd;
  logic             have_q, have_d, eff_have;
  logic             prev_q, prev_d;
  logic             qv_q, qv_d, qb_q, qb_d;
  logic             cur_bit;
  logic             state_en;
  step_mode_e       mode;

  assign mode = step_mode_e'(adapt_mode_i);

  adq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  adq_gray2bin #(.W(PIX_W)) u_g2b (.gray_i(px_gray_i), .bin_o(pix_bin));

  // frame start substitutes the restored state before comparison
  always_comb begin
    eff_bp   = frame_start_i ? BP_MID      : bp_q;
    eff_step = frame_start_i ? step_init_i : step_q;
    eff_have = frame_start_i ? 1'b0        : have_q;
    cur_bit  = (pix_bin > eff_bp);
  end

  adq_bp_update #(.W(PIX_W)) u_bpu (
    .bp_i(eff_bp), .step_i(eff_step), .up_i(cur_bit), .bp_next_o(bp_upd)
  );

  adq_step_ctrl #(.W(PIX_W), .SHIFT(SHIFT)) u_stp (
    .step_i(eff_step), .step_init_i(step_init_i), .mode_i(mode),
    .have_prev_i(eff_have), .prev_bit_i(prev_q), .cur_bit_i(cur_bit),
    .step_next_o(step_upd)
  );

  always_comb begin
    state_en = px_valid_i | frame_start_i | bp_load_i;
    bp_d     = eff_bp;
    step_d   = eff_step;
    have_d   = eff_have;
    prev_d   = prev_q;
    if (px_valid_i) begin
      bp_d   = bp_upd;
      step_d = step_upd;
      have_d = 1'b1;
      prev_d = cur_bit;
    end
    if (bp_load_i) bp_d = bp_load_val_i;
    qv_d = px_valid_i;
    qb_d = px_valid_i ? cur_bit : qb_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      bp_q   <= BP_MID;
      step_q <= STEP_R0;
      have_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (state_en) begin
      bp_q   <= bp_d;
      step_q <= step_d;
      have_q <= have_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      qv_q <= 1'b0;
      qb_q <= 1'b0;
    end else begin
      qv_q <= qv_d;
      qb_q <= qb_d;
    end
  end

  assign q_valid_o = qv_q;
  assign q_bit_o   = qb_q;
  assign bp_o      = bp_q;
  assign step_o    = step_q;
endmodule

// File: rtl/adq_quantizer_chk.sv
module adq_quantizer_chk #(
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             px_valid_i,
  input logic             frame_start_i,
  input logic             adapt_mode_i,
  input logic             bp_load_i,
  input logic [PIX_W-1:0] bp_load_val_i,
  input logic             q_valid_o,
  input logic             q_bit_o,
  input logic [PIX_W-1:0] bp_o,
  input logic [PIX_W-1:0] step_o
);
  localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);

  // R3
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid_i |=> q_valid_o);
  // R3
  no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid_i |=> !q_valid_o);
  // R4
  bp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid_i && !bp_load_i && !frame_start_i) |=> (!q_bit_o || bp_o >= $past(bp_o)));
  // R5
  bp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid_i && !bp_load_i && !frame_start_i) |=> (q_bit_o || bp_o <= $past(bp_o)));
  // R9
  bp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp_load_i |=> (bp_o == $past(bp_load_val_i)));
  // R8
  fixed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adapt_mode_i && !frame_start_i) |=> $stable(step_o));
  // R2
  frame_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && !bp_load_i && !px_valid_i) |=> (bp_o == MID));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!px_valid_i && !bp_load_i && !frame_start_i) |=> ($stable(bp_o) && $stable(step_o) && $stable(q_bit_o)));
endmodule

bind adq_quantizer adq_quantizer_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .px_valid_i(px_valid_i),
  .frame_start_i(frame_start_i), .adapt_mode_i(adapt_mode_i),
  .bp_load_i(bp_load_i), .bp_load_val_i(bp_load_val_i),
  .q_valid_o(q_valid_o), .q_bit_o(q_bit_o), .bp_o(bp_o), .step_o(step_o)
);

// File: tb/sim_adq_quantizer.sv
`timescale 1ns/1ps
module sim_adq_quantizer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       px_valid_i, frame_start_i, adapt_mode_i, bp_load_i;
  logic [7:0] px_gray_i, step_init_i, bp_load_val_i;
  logic       q_valid_o, q_bit_o;
  logic [7:0] bp_o, step_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int m_bp, m_step;
  bit m_have, m_prev, m_bit;

  always #2.5 clk = ~clk;

  adq_quantizer u0 (
    .clk(clk), .rst_n(rst_n), .px_valid_i(px_valid_i), .px_gray_i(px_gray_i),
    .frame_start_i(frame_start_i), .adapt_mode_i(adapt_mode_i),
    .step_init_i(step_init_i), .bp_load_i(bp_load_i), .bp_load_val_i(bp_load_val_i),
    .q_valid_o(q_valid_o), .q_bit_o(q_bit_o), .bp_o(bp_o), .step_o(step_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one cycle of stimulus; pixel given in binary, driven Gray-coded (R1)
  task automatic cyc(input bit v, input int pbin, input bit fs, input bit mode,
                     input bit ld, input int ldv, input string bit_tag);
    int ebp, est, nbp, nst;
    bit eh, b;
    string bp_tag, st_tag;
    ebp = m_bp; est = m_step; eh = m_have;
    if (fs) begin ebp = 128; est = int'(step_init_i); eh = 0; end
    b = (pbin > ebp);
    nbp = ebp; nst = est;
    bp_tag = fs ? "R2" : "R10";
    st_tag = fs ? "R2" : (mode ? "R7" : "R8");
    if (v) begin
      if (b) begin nbp = (ebp + est > 255) ? 255 : ebp + est; bp_tag = "R4"; end
      else   begin nbp = (ebp - est < 0) ? 0 : ebp - est;     bp_tag = "R5"; end
      if (mode && eh) begin
        if (b == m_prev) begin nst = est + est / 8; if (nst > 255) nst = 255; st_tag = "R6"; end
        else begin nst = int'(step_init_i); st_tag = "R7"; end
      end
      m_have = 1; m_prev = b; m_bit = b;
    end else begin
      m_have = eh;
    end
    if (ld) begin nbp = ldv; bp_tag = "R9"; end
    m_bp = nbp; m_step = nst;
    px_valid_i    = v;
    px_gray_i     = 8'(pbin) ^ (8'(pbin) >> 1);
    frame_start_i = fs;
    adapt_mode_i  = mode;
    bp_load_i     = ld;
    bp_load_val_i = 8'(ldv);
    @(negedge clk);
    check("R3 valid", int'(q_valid_o), int'(v));
    check({bit_tag, " bit"}, int'(q_bit_o), int'(m_bit));
    check({bp_tag, " boundary"}, int'(bp_o), m_bp);
    check({st_tag, " step"}, int'(step_o), m_step);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; px_valid_i = 0; px_gray_i = 0; frame_start_i = 0;
    adapt_mode_i = 0; step_init_i = 8'd16; bp_load_i = 0; bp_load_val_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R2 reset state
    check("R2 reset boundary", int'(bp_o), 128);
    check("R2 reset step", int'(step_o), 16);
    check("R3 reset valid", int'(q_valid_o), 0);
    m_bp = 128; m_step = 16; m_have = 0; m_prev = 0; m_bit = 0;

    // R1/R3: every pixel code against a fresh mid-range boundary
    for (int p = 0; p < 256; p++) cyc(1, p, 1, 0, 0, 0, "R1");

    // R2: standalone frame start, then idle (R10)
    step_init_i = 8'd20;
    cyc(0, 0, 1, 1, 0, 0, "R3");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, 0, "R10");

    // adaptive streams with several start steps (R6, R7)
    lfsr = 16'hACE1;
    for (int s = 0; s < 3; s++) begin
      step_init_i = (s == 0) ? 8'd14 : (s == 1) ? 8'd18 : 8'd20;
      for (int i = 0; i < 600; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc(lfsr[0] | lfsr[1], (i % 128 < 64) ? int'(lfsr[15:8] & 8'h3F) + 60 : int'(lfsr[15:8]),
            (i % 97) == 0, 1, 0, 0, "R3");
      end
    end

    // constant input: step grows on runs and resets on flips
    step_init_i = 8'd16;
    cyc(1, 200, 1, 1, 0, 0, "R3");
    for (int i = 0; i < 30; i++) cyc(1, 200, 0, 1, 0, 0, "R3");

    // fixed mode stream (R8)
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(1, int'(lfsr[7:0]), i == 0, 0, 0, 0, "R3");
    end

    // saturation of the boundary point at both ends (R4, R5)
    cyc(0, 0, 0, 0, 1, 250, "R9");
    cyc(1, 255, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 1, 5, "R9");
    cyc(1, 0, 0, 0, 0, 0, "R5");

    // step saturation: keep loading a low boundary with full pixels (R6, R9)
    step_init_i = 8'd200;
    cyc(1, 255, 1, 1, 1, 0, "R9");
    for (int i = 0; i < 6; i++) cyc(1, 255, 0, 1, 1, 0, "R6");

    // load beats frame start; load alone; load with pixel
    step_init_i = 8'd16;
    cyc(0, 0, 1, 1, 1, 77, "R9");
    cyc(1, 90, 0, 1, 1, 33, "R9");
    cyc(0, 0, 0, 1, 0, 0, "R10");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule